// File: doc/BRIEF.md
# Range Coder Low Register Update Stage

This block is the third stage of a pipelined multi-symbol range encoder. Each cycle the earlier stages hand it a ready-made increment for the low register and a renormalization shift count, qualified by a valid flag. The stage adds the increment to low. It then uses a signed bit counter to decide whether whole bytes have settled at the top of the low window. If they have, it pulls out one or two of them, and finally shifts low left by the renormalization amount.

The extracted bytes are 9 bits wide. Bit 8 is a carry that has not been resolved yet, and a later carry-propagation stage folds it into bytes already sent. The stage also exports its current low and counter values so that end-of-frame flush logic can drain what remains. A frame-start pulse returns the stage to its initial state.

Top module: `rc_low_update`

## Requirements
- R1: After the asynchronous active-low reset, lowOut is 0, cntOut is -9 and outCount is 0.
- R2: A frameStart pulse sets lowOut to 0, cntOut to -9 and outCount to 0 on the next edge. It takes priority over validIn, so a symbol presented in the same cycle is dropped.
- R3: When validIn is low (and frameStart low), lowOut and cntOut keep their values and outCount reads 0 in the following cycle.
- R4: For an accepted symbol, with sum = lowOut + lowInc (modulo 2^LOW_W) and s = cntOut + shift: if s < 0, outCount becomes 0, cntOut becomes s and lowOut becomes sum << shift.
- R5: If 0 <= s < 8, exactly one byte is emitted. outCount becomes 1, outByte0 holds bits [c+8:c] of sum with c = cntOut + 16, and cntOut becomes s - 8.
- R6: If s >= 8, two bytes are emitted and outCount becomes 2. outByte0 is the first byte in stream order and holds bits [c+8:c] of sum. outByte1 holds bits [c-1:c-8] of sum with bit 8 zero. cntOut becomes s - 16.
- R7: After an emission, lowOut becomes the bits of sum below the last extraction position (c for one byte, c-8 for two), shifted left by shift.
- R8: All results of a symbol appear on the outputs one cycle after it is presented. For any sequence of shifts in 0..15, cntOut stays within -9..-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Reinitializes low and counter |
| validIn | input | 1 | Symbol operands valid this cycle |
| lowInc | input | INC_W | Increment to add to low |
| shift | input | SHIFT_W | Renormalization shift count (0..15) |
| outCount | output | 2 | Number of bytes produced (0, 1, 2) |
| outByte0 | output | 9 | First pre-carry byte, bit 8 is carry |
| outByte1 | output | 9 | Second pre-carry byte |
| lowOut | output | LOW_W | Current low register |
| cntOut | output | CNT_W | Current signed bit counter |

## Verification
A wrong counter value first shows up as a byte count that differs from the expected one. The next byte values also come out of the wrong bit window of low, and both appear one cycle after the symbol is presented. A corrupted low register may hide for several symbols until its upper bits reach the extraction window. Because low and the counter are visible on the ports, a bench that compares them every cycle catches either fault in the same cycle it occurs.

// File: rtl/rc_low_pkg.sv
package rc_low_pkg;
  typedef struct packed {
    logic init;
    logic load;
    logic emitOne;
    logic emitTwo;
  } lowStrobe_t;
endpackage

// File: rtl/rc_low_ctrl.sv
module rc_low_ctrl
  import rc_low_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 4
) (
  input  logic                     frameStart,
  input  logic                     validIn,
  input  logic signed [CNT_W-1:0]  cntCur,
  input  logic [SHIFT_W-1:0]       shift,
  output logic signed [CNT_W-1:0]  sumCnt,
  output lowStrobe_t               strobe
);
  localparam int PAD_W = CNT_W - SHIFT_W;
  localparam logic signed [CNT_W-1:0] TWO_LIMIT = CNT_W'(8);

  logic signed [CNT_W-1:0] shiftExt;

  always_comb begin
    shiftExt = $signed({{PAD_W{1'b0}}, shift});
    sumCnt   = cntCur + shiftExt;
    strobe.init    = frameStart;
    strobe.load    = validIn && !frameStart;
    strobe.emitTwo = strobe.load && (sumCnt >= TWO_LIMIT);
    strobe.emitOne = strobe.load && !sumCnt[CNT_W-1] && (sumCnt < TWO_LIMIT);
  end
endmodule

// File: rtl/rc_low_dp.sv
module rc_low_dp
  import rc_low_pkg::*;
#(
  parameter int LOW_W   = 32,
  parameter int INC_W   = 16,
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 4,
  parameter int BYTE_W  = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lowStrobe_t               strobe,
  input  logic signed [CNT_W-1:0]  sumCnt,
  input  logic [INC_W-1:0]         lowInc,
  input  logic [SHIFT_W-1:0]       shift,
  output logic [LOW_W-1:0]         lowReg,
  output logic signed [CNT_W-1:0]  cntReg,
  output logic [BYTE_W-1:0]        byte0,
  output logic [BYTE_W-1:0]        byte1,
  output logic [1:0]               outCount
);
  localparam int DATA_BITS = BYTE_W - 1;
  localparam int TOP_OFS   = 2 * DATA_BITS;
  localparam logic signed [CNT_W-1:0] CNT_INIT = -CNT_W'(BYTE_W);

  logic [LOW_W-1:0] sumLow, shiftedTop, shiftedLow, keepMask, baseLow, nextLow;
  logic [CNT_W-1:0] posTop, posLow, keepPos;
  logic signed [CNT_W-1:0] nextCnt;
  logic [1:0] nextCount;

  always_comb begin
    sumLow     = lowReg + LOW_W'(lowInc);
    posTop     = cntReg + CNT_W'(TOP_OFS);
    posLow     = posTop - CNT_W'(DATA_BITS);
    shiftedTop = sumLow >> posTop;
    shiftedLow = sumLow >> posLow;
    keepPos    = strobe.emitTwo ? posLow : posTop;
    keepMask   = (LOW_W'(1) << keepPos) - LOW_W'(1);
    baseLow    = (strobe.emitOne || strobe.emitTwo) ? (sumLow & keepMask) : sumLow;
    nextLow    = baseLow << shift;
    if (strobe.emitTwo) begin
      nextCnt   = sumCnt - CNT_W'(TOP_OFS);
      nextCount = 2'd2;
    end else if (strobe.emitOne) begin
      nextCnt   = sumCnt - CNT_W'(DATA_BITS);
      nextCount = 2'd1;
    end else begin
      nextCnt   = sumCnt;
      nextCount = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowReg   <= '0;
      cntReg   <= CNT_INIT;
      byte0    <= '0;
      byte1    <= '0;
      outCount <= '0;
    end else if (strobe.init) begin
      lowReg   <= '0;
      cntReg   <= CNT_INIT;
      byte0    <= '0;
      byte1    <= '0;
      outCount <= '0;
    end else if (strobe.load) begin
      lowReg   <= nextLow;
      cntReg   <= nextCnt;
      outCount <= nextCount;
      if (strobe.emitOne || strobe.emitTwo) begin
        byte0 <= shiftedTop[BYTE_W-1:0];
      end
      if (strobe.emitTwo) begin
        byte1 <= {1'b0, shiftedLow[DATA_BITS-1:0]};
      end else if (strobe.emitOne) begin
        byte1 <= '0;
      end
    end else begin
      outCount <= '0;
    end
  end
endmodule

// File: rtl/rc_low_update.sv
module rc_low_update
  import rc_low_pkg::*;
#(
  parameter int LOW_W   = 32,
  parameter int INC_W   = 16,
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStart,
  input  logic                     validIn,
  input  logic [INC_W-1:0]         lowInc,
  input  logic [SHIFT_W-1:0]       shift,
  output logic [1:0]               outCount,
  output logic [8:0]               outByte0,
  output logic [8:0]               outByte1,
  output logic [LOW_W-1:0]         lowOut,
  output logic signed [CNT_W-1:0]  cntOut
);
  lowStrobe_t strobe;
  logic signed [CNT_W-1:0] sumCnt;

  rc_low_ctrl #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_ctrl (
    .frameStart(frameStart), .validIn(validIn), .cntCur(cntOut),
    .shift(shift), .sumCnt(sumCnt), .strobe(strobe)
  );

  rc_low_dp #(.LOW_W(LOW_W), .INC_W(INC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .BYTE_W(9)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sumCnt(sumCnt),
    .lowInc(lowInc), .shift(shift), .lowReg(lowOut), .cntReg(cntOut),
    .byte0(outByte0), .byte1(outByte1), .outCount(outCount)
  );
endmodule

// File: rtl/rc_low_update_chk.sv
module rc_low_update_chk #(
  parameter int LOW_W   = 32,
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     frameStart,
  input logic                     validIn,
  input logic [SHIFT_W-1:0]       shift,
  input logic [1:0]               outCount,
  input logic [8:0]               outByte1,
  input logic [LOW_W-1:0]         lowOut,
  input logic signed [CNT_W-1:0]  cntOut
);
  AST_INIT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (lowOut == '0) && (cntOut == -9) && (outCount == 2'd0)); // R2

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!validIn && !frameStart) |=> $stable(lowOut) && $stable(cntOut) && (outCount == 2'd0)); // R3

  AST_ZERO_SHIFT_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !frameStart && shift == '0) |=> (cntOut == $past(cntOut)) && (outCount == 2'd0)); // R4

  AST_SECOND_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (outCount == 2'd2) |-> (outByte1[8] == 1'b0)); // R6

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    outCount != 2'd3); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cntOut >= -9) && (cntOut <= -1)); // R8
endmodule

bind rc_low_update rc_low_update_chk #(.LOW_W(LOW_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .validIn(validIn), .shift(shift),
  .outCount(outCount), .outByte1(outByte1), .lowOut(lowOut), .cntOut(cntOut)
);

// File: tb/rc_low_update_test.sv
`timescale 1ns/1ps
module rc_low_update_test;
  localparam int LOW_W = 32;
  localparam int INC_W = 16;
  localparam int CNT_W = 6;
  localparam int SHIFT_W = 4;
  localparam int NVEC = 16;

  // vector: {validIn, shift[3:0], lowInc[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 4'd5,  16'h1234},
    {1'b1, 4'd6,  16'h0F0F},
    {1'b0, 4'd9,  16'hFFFF},
    {1'b1, 4'd15, 16'hABCD},
    {1'b1, 4'd0,  16'h0001},
    {1'b1, 4'd8,  16'hFFFF},
    {1'b1, 4'd1,  16'h8000},
    {1'b1, 4'd7,  16'h7FFF},
    {1'b1, 4'd15, 16'hFFFF},
    {1'b1, 4'd15, 16'hFFFF},
    {1'b0, 4'd0,  16'h0000},
    {1'b1, 4'd3,  16'h00FF},
    {1'b1, 4'd12, 16'hC3A5},
    {1'b1, 4'd2,  16'h5A5A},
    {1'b1, 4'd9,  16'hFFFE},
    {1'b1, 4'd4,  16'h0100}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic validIn = 1'b0;
  logic [INC_W-1:0] lowInc = '0;
  logic [SHIFT_W-1:0] shift = '0;
  logic [1:0] outCount;
  logic [8:0] outByte0, outByte1;
  logic [LOW_W-1:0] lowOut;
  logic signed [CNT_W-1:0] cntOut;

  int nChecks = 0;
  int nFails = 0;

  logic [LOW_W-1:0] mLow;
  int mCnt;
  int eCount;
  logic [8:0] eB0, eB1;

  always #2 clk = ~clk;

  rc_low_update #(.LOW_W(LOW_W), .INC_W(INC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .validIn(validIn),
    .lowInc(lowInc), .shift(shift), .outCount(outCount), .outByte0(outByte0),
    .outByte1(outByte1), .lowOut(lowOut), .cntOut(cntOut)
  );

  task automatic modelInit();
    mLow = '0; mCnt = -9; eCount = 0; eB0 = '0; eB1 = '0;
  endtask

  task automatic modelStep(input logic fs, input logic v, input int d, input logic [INC_W-1:0] inc);
    logic [LOW_W-1:0] sum;
    int s, c;
    if (fs) begin
      modelInit();
    end else if (!v) begin
      eCount = 0;
    end else begin
      sum = mLow + LOW_W'(inc);
      s = mCnt + d;
      c = mCnt + 16;
      if (s >= 8) begin
        eCount = 2;
        eB0 = 9'((sum >> c) & 32'h1FF);
        eB1 = 9'((sum >> (c - 8)) & 32'hFF);
        mLow = (sum & ((LOW_W'(1) << (c - 8)) - 1)) << d;
        mCnt = s - 16;
      end else if (s >= 0) begin
        eCount = 1;
        eB0 = 9'((sum >> c) & 32'h1FF);
        eB1 = '0;
        mLow = (sum & ((LOW_W'(1) << c) - 1)) << d;
        mCnt = s - 8;
      end else begin
        eCount = 0;
        mLow = sum << d;
        mCnt = s;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic bad;
    nChecks++;
    bad = 1'b0;
    if (int'(outCount) != eCount) begin
      bad = 1'b1;
      $display("FAIL %s outCount actual %0d expected %0d", tag, outCount, eCount);
    end
    if (eCount >= 1 && outByte0 != eB0) begin
      bad = 1'b1;
      $display("FAIL %s outByte0 actual %h expected %h", tag, outByte0, eB0);
    end
    if (eCount == 2 && outByte1 != eB1) begin
      bad = 1'b1;
      $display("FAIL %s outByte1 actual %h expected %h", tag, outByte1, eB1);
    end
    if (lowOut != mLow) begin
      bad = 1'b1;
      $display("FAIL %s/R7 lowOut actual %h expected %h", tag, lowOut, mLow);
    end
    if (int'(cntOut) != mCnt) begin
      bad = 1'b1;
      $display("FAIL %s/R8 cntOut actual %0d expected %0d", tag, cntOut, mCnt);
    end
    if (bad) nFails++;
  endtask

  function automatic string tagFor(input logic fs, input logic v, input int cnt, input int d);
    if (fs) return "R2";
    if (!v) return "R3";
    if (cnt + d >= 8) return "R6";
    if (cnt + d >= 0) return "R5";
    return "R4";
  endfunction

  task automatic step(input logic fs, input logic v, input int d, input logic [INC_W-1:0] inc);
    string tag;
    @(negedge clk);
    tag = tagFor(fs, v, mCnt, d);
    frameStart = fs; validIn = v; shift = SHIFT_W'(d); lowInc = inc;
    modelStep(fs, v, d, inc);
    @(negedge clk);
    frameStart = 1'b0; validIn = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    modelInit();
    #5;
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, VEC[i][20], int'(VEC[i][19:16]), VEC[i][15:0]);
    end

    // R2: frame start overrides a valid symbol
    step(1'b1, 1'b1, 15, 16'hFFFF);
    // R4: first symbol after init with small shift, no byte
    step(1'b0, 1'b1, 8, 16'h4321);
    // R5: reaches s = 0 exactly
    step(1'b0, 1'b1, 1, 16'h0007);
    // R3: idle cycles hold state
    step(1'b0, 1'b0, 12, 16'hFFFF);
    step(1'b0, 1'b0, 3, 16'h1111);
    // R6: s exactly 8 from cnt -7 after re-init
    step(1'b1, 1'b0, 0, 16'h0000);
    step(1'b0, 1'b1, 2, 16'hFFFF);
    step(1'b0, 1'b1, 15, 16'hFFFF);

    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, lfsr[0] | lfsr[1], int'(lfsr[5:2]), {lfsr[7:0], lfsr[15:8]});
    end

    // R1: asynchronous reset mid-stream
    @(negedge clk);
    rstN = 1'b0;
    #1;
    modelInit();
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b1, 9, 16'h8001);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule